// File: doc/BRIEF.md
# Dual Multiply-Subtract Long Accumulator

This block takes two 32-bit operands, each packing a pair of signed 16-bit halves, and a signed 64-bit accumulator delivered as a high word and a low word. It forms two signed 16x16 products. The upper-half product is subtracted from the lower-half product. The difference, widened with its sign, is added to the accumulator. The 64-bit sum comes back as a high word and a low word. A per-transfer exchange flag can swap the two halves of the second operand before the multiplies. The products are then cross-paired: low of A with high of B, and high of A with low of B.

Operands enter on a valid/ready stream and results leave on another valid/ready stream. The transfer rules are as follows. A transfer happens on a rising edge where valid and ready are both high. `in_rdy` is high whenever the output register is empty or the sink is taking its word (`in_rdy = !out_vld || out_rdy`). A producer may change its data only after a transfer. A result shown on `out_vld` holds its value until the sink takes it. While the output stalls, the whole two-stage pipeline freezes. With `out_rdy` held high, one operation is accepted on every cycle.

Top module: `dmsl_top`

## Requirements
- R1: With `in_xchg`=0, the value added to the accumulator is signed(A[15:0])*signed(B[15:0]) minus signed(A[31:16])*signed(B[31:16]).
- R2: With `in_xchg`=1, B's halves are swapped first, so the added value is signed(A[15:0])*signed(B[31:16]) minus signed(A[31:16])*signed(B[15:0]).
- R3: The accumulator is the signed 64-bit value {`in_acc_hi`,`in_acc_lo`} (high word is bits 63:32). `out_hi` carries sum bits 63:32 and `out_lo` carries sum bits 31:0.
- R4: Overflow of the 64-bit addition wraps modulo 2^64 and raises no flag.
- R5: A negative product difference is sign-extended, so it lowers the accumulator, and a borrow can ripple from the low word into the high word.
- R6: When both halves of both operands are -32768, both products equal +2^30 and the added value is zero.
- R7: With `out_rdy` high, a transfer accepted at rising edge n appears on `out_vld`/`out_hi`/`out_lo` after rising edge n+1. Transfers on consecutive cycles emerge on consecutive cycles in order.
- R8: While `out_vld`=1 and `out_rdy`=0, `out_vld`, `out_hi` and `out_lo` hold their values and `in_rdy` is 0.
- R9: A synchronous active-high `rst` clears `out_vld` to 0 and leaves `in_rdy`=1 afterwards, discarding work in flight.
- R10: The product difference always fits in 32 signed bits, so the only overflow possible is in the 64-bit addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input transfer valid |
| in_rdy | output | 1 | Block can accept an input transfer |
| in_a | input | 32 | Operand A, two signed halves |
| in_b | input | 32 | Operand B, two signed halves |
| in_xchg | input | 1 | Swap halves of B before multiplying |
| in_acc_hi | input | 32 | Accumulator bits 63:32 |
| in_acc_lo | input | 32 | Accumulator bits 31:0 |
| out_vld | output | 1 | Result valid |
| out_rdy | input | 1 | Sink accepts the result |
| out_hi | output | 32 | Result bits 63:32 |
| out_lo | output | 32 | Result bits 31:0 |

## Verification
Several behaviours are checked on every cycle by the assertions. An accepted transfer must fill stage one. A filled stage one must reach the output when the pipe advances, and a bubble must not. A stalled result must hold steady. The 33-bit product difference must never need its extra bit. The arithmetic itself can only be shown by the bench's vectors: the lane pairing with and without exchange, sign extension with a borrow across words, wrap at both ends of the 64-bit range, and the double -32768 case. The bench's directed scenarios also cover reset clearing work in flight and the ready signal falling during a stall.

// File: rtl/dmsl_pkg.sv
package dmsl_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned PROD_W = 2 * HALF_W;
  localparam int unsigned DIFF_W = PROD_W + 1;
  localparam int unsigned ACC_W  = 2 * WORD_W;

  typedef logic [WORD_W-1:0]        word_t;
  typedef logic signed [HALF_W-1:0] half_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [DIFF_W-1:0] diff_t;
  typedef logic [ACC_W-1:0]         acc_t;

  typedef enum logic [0:0] {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/dmsl_halfswap.sv
module dmsl_halfswap
  import dmsl_pkg::*;
(
  input  word_t src,
  input  logic  xchg,
  output half_t lane_lo,
  output half_t lane_hi
);
  always_comb begin
    if (xchg) begin
      lane_lo = half_t'(src[WORD_W-1:HALF_W]);
      lane_hi = half_t'(src[HALF_W-1:0]);
    end else begin
      lane_lo = half_t'(src[HALF_W-1:0]);
      lane_hi = half_t'(src[WORD_W-1:HALF_W]);
    end
  end
endmodule

// File: rtl/dmsl_mul16.sv
module dmsl_mul16
  import dmsl_pkg::*;
(
  input  half_t x,
  input  half_t y,
  output prod_t p
);
  always_comb p = x * y;
endmodule

// File: rtl/dmsl_acc_add.sv
module dmsl_acc_add
  import dmsl_pkg::*;
(
  input  prod_t p_first,
  input  prod_t p_second,
  input  acc_t  acc,
  output diff_t diff,
  output acc_t  sum
);
  localparam int unsigned EXT_W = ACC_W - DIFF_W;
  diff_t ext_first, ext_second;
  acc_t  diff_wide;

  always_comb begin
    ext_first  = {p_first[PROD_W-1], p_first};
    ext_second = {p_second[PROD_W-1], p_second};
    diff       = ext_first - ext_second;
    diff_wide  = {{EXT_W{diff[DIFF_W-1]}}, diff};
    sum        = acc + diff_wide;
  end
endmodule

// File: rtl/dmsl_top.sv
module dmsl_top
  import dmsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  output logic              in_rdy,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_xchg,
  input  logic [WORD_W-1:0] in_acc_hi,
  input  logic [WORD_W-1:0] in_acc_lo,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic [WORD_W-1:0] out_hi,
  output logic [WORD_W-1:0] out_lo
);
  localparam int unsigned LANES = 2;

  half_t a_lane [LANES];
  half_t b_lane [LANES];
  prod_t prod   [LANES];

  dmsl_halfswap u_swap_a (.src(in_a), .xchg(1'b0),    .lane_lo(a_lane[LANE_LO]), .lane_hi(a_lane[LANE_HI]));
  dmsl_halfswap u_swap_b (.src(in_b), .xchg(in_xchg), .lane_lo(b_lane[LANE_LO]), .lane_hi(b_lane[LANE_HI]));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dmsl_mul16 u_mul (.x(a_lane[g]), .y(b_lane[g]), .p(prod[g]));
  end

  logic  advance;
  logic  s1_vld, s2_vld;
  prod_t s1_p_first, s1_p_second;
  acc_t  s1_acc, s2_sum;
  diff_t s1_diff;
  acc_t  s1_sum;

  assign advance = !s2_vld || out_rdy;
  assign in_rdy  = advance;

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else if (advance) s1_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (advance && in_vld) begin
      s1_p_first  <= prod[LANE_LO];
      s1_p_second <= prod[LANE_HI];
      s1_acc      <= {in_acc_hi, in_acc_lo};
    end
  end

  dmsl_acc_add u_add (
    .p_first (s1_p_first),
    .p_second(s1_p_second),
    .acc     (s1_acc),
    .diff    (s1_diff),
    .sum     (s1_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) s2_vld <= 1'b0;
    else if (advance) s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    if (advance && s1_vld) s2_sum <= s1_sum;
  end

  assign out_vld = s2_vld;
  assign out_hi  = s2_sum[ACC_W-1:WORD_W];
  assign out_lo  = s2_sum[WORD_W-1:0];

  AST_S1_FILL: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_rdy) |=> s1_vld); // R7
  AST_OUT_FILL: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && in_rdy) |=> out_vld); // R7
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    (!s1_vld && in_rdy) |=> !out_vld); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_hi) && $stable(out_lo))); // R8
  AST_DIFF_FITS: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> (s1_diff[DIFF_W-1] == s1_diff[DIFF_W-2])); // R10
endmodule

// File: tb/dmsl_top_tb_top.sv
module dmsl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0, in_xchg = 1'b0, out_rdy = 1'b1;
  logic [31:0] in_a = '0, in_b = '0, in_acc_hi = '0, in_acc_lo = '0;
  logic        in_rdy, out_vld;
  logic [31:0] out_hi, out_lo;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dmsl_top dut_i (.clk, .rst, .in_vld, .in_rdy, .in_a, .in_b, .in_xchg,
                  .in_acc_hi, .in_acc_lo, .out_vld, .out_rdy, .out_hi, .out_lo);

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        x;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h0003_0002, 32'h0005_0007, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R1
    '{32'h0003_0002, 32'h0005_0007, 1'b1, 32'h0000_0000, 32'h0000_0000}, // R2
    '{32'h8000_8000, 32'h8000_8000, 1'b0, 32'h0000_0000, 32'h0000_0064}, // R6
    '{32'h7FFF_8000, 32'h8000_7FFF, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0}, // R2
    '{32'h0000_0001, 32'h0000_0001, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF}, // R4
    '{32'h0000_0001, 32'h0000_0001, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R4
    '{32'h0001_0000, 32'h0001_0000, 1'b0, 32'h0000_0001, 32'h0000_0000}, // R5
    '{32'h1234_ABCD, 32'hFEDC_5678, 1'b1, 32'h0123_4567, 32'h89AB_CDEF}  // R3
  };

  function automatic logic [63:0] model(vec_t v);
    logic [31:0] bb;
    longint p1, p2, acc;
    bb  = v.x ? {v.b[15:0], v.b[31:16]} : v.b;
    p1  = longint'($signed(v.a[15:0])) * longint'($signed(bb[15:0]));
    p2  = longint'($signed(v.a[31:16])) * longint'($signed(bb[31:16]));
    acc = longint'({v.hi, v.lo});
    return 64'(acc + (p1 - p2));
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(vec_t v, logic vld);
    in_vld = vld; in_a = v.a; in_b = v.b; in_xchg = v.x;
    in_acc_hi = v.hi; in_acc_lo = v.lo;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset out_vld", 64'(out_vld), 64'd0);
    chk("R9 reset in_rdy", 64'(in_rdy), 64'd1);

    // Table walk, back-to-back, out_rdy high: vector c driven at negedge c, checked at negedge c+2
    for (int c = 0; c < NV + 2; c++) begin
      if (c >= 2) begin
        chk("R7 valid", 64'(out_vld), 64'd1);
        chk("R1 R2 R3 R4 R5 R6 result", {out_hi, out_lo}, model(VECS[c-2]));
      end
      if (c < NV) drive(VECS[c], 1'b1); else in_vld = 1'b0;
      @(negedge clk);
    end
    chk("R7 drained", 64'(out_vld), 64'd0);

    // Double -32768 corner: zero added value leaves the accumulator unchanged
    drive('{32'h8000_8000, 32'h8000_8000, 1'b1, 32'hDEAD_BEEF, 32'h0BAD_F00D}, 1'b1);
    @(negedge clk); in_vld = 1'b0;
    @(negedge clk);
    chk("R6 zero diff", {out_hi, out_lo}, 64'hDEAD_BEEF_0BAD_F00D);

    // Back-pressure
    drive(VECS[7], 1'b1);
    @(negedge clk); in_vld = 1'b0; out_rdy = 1'b0;
    @(negedge clk);
    chk("R8 stalled valid", 64'(out_vld), 64'd1);
    chk("R8 in_rdy low", 64'(in_rdy), 64'd0);
    repeat (3) @(negedge clk);
    chk("R8 held valid", 64'(out_vld), 64'd1);
    chk("R8 held data", {out_hi, out_lo}, model(VECS[7]));
    chk("R8 in_rdy still low", 64'(in_rdy), 64'd0);
    out_rdy = 1'b1;
    @(negedge clk);
    chk("R8 released", 64'(out_vld), 64'd0);
    chk("R8 ready again", 64'(in_rdy), 64'd1);

    // Reset with work in flight
    drive(VECS[0], 1'b1);
    @(negedge clk); drive(VECS[1], 1'b1);
    @(negedge clk); in_vld = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 flush valid", 64'(out_vld), 64'd0);
    @(negedge clk);
    chk("R9 flush stays empty", 64'(out_vld), 64'd0);
    chk("R9 flush ready", 64'(in_rdy), 64'd1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule